// File: doc/BRIEF.md
# Dual-Path Pulsed Envelope Sequencer

This block plays out two time-aligned sample streams for every period of a pulsed RF system. One stream commands the supply voltage of a power amplifier. The other commands the amplitude of its RF baseband drive. Both streams are unsigned 16-bit converter codes. A single strobe marks each sample, and the strobes come at an average of one sample per 12.5 system clocks, which is 10 Msps from a 125 MHz clock. A master trigger marks the first sample of each period so that external capture equipment can lock to it.

Each path plays, in order, an optional lead-in, a rising segment read sample by sample from its own preloaded shaping table, a flat top at full scale, and then silence until the period ends. The supply path's lead-in is a fixed low pedestal that keeps the supply at a usable minimum before the pulse. The RF path has no pedestal, and its pulse starts a programmable number of samples after the supply pulse, so that the drive and the supply stay aligned. Each path has its own gain, which scales the table and the flat top. The result is clamped to full scale.

The timing values, the pedestal level and both gains are captured at each period boundary, so a new setting takes effect on the next period and never partway through one. The run input is also sampled only at period boundaries. A stop request therefore always completes the period in progress.

Top module: `env_pulse_seq`

## Requirements
- R1: While running, consecutive sample strobes (`smp_valid`, one clock wide) are alternately 12 and 13 clock cycles apart, for an average of 12.5 clocks per sample.
- R2: `smp_trig` is high for exactly one clock, together with the strobe of sample index 0 of every period, and at no other time.
- R3: On the supply path, sample indices below `cfg_ped_len` output the pedestal code `cfg_ped_level`, without scaling.
- R4: On the supply path, indices from `cfg_ped_len` to `cfg_ped_len+cfg_ramp_len-1` output supply table entry (index − `cfg_ped_len`), times `cfg_sup_gain`, shifted right 12 bits. The gain is unsigned Q4.12, so 0x1000 means 1.0.
- R5: After its ramp, a path outputs 0xFFFF scaled by its gain until `cfg_pulse_len` samples after its pulse start, and 0 from then until the period ends. A `cfg_ramp_len` of 0 starts the flat top immediately. Any scaled value above 0xFFFF is clamped to 0xFFFF.
- R6: The RF path uses the same shape, starting at index `cfg_ped_len+cfg_delay`, with its own table and `cfg_rf_gain`. It outputs 0 before its start. A delay that is at or beyond the period end keeps the RF path at 0.
- R7: The period, pedestal length, pulse length, ramp length, delay, pedestal level and both gains are captured only at a period boundary. A change made during a period has no effect until the next period.
- R8: `run` is sampled at period boundaries. When idle, a high `run` starts a period with index 0 at the second strobe slot. When `run` is low at the end of a period, strobes stop and outputs hold their values.
- R9: A table write with `tbl_we` high stores `tbl_data` at `tbl_addr` in the supply table when `tbl_sel` is 0, and in the RF table when `tbl_sel` is 1. The other table is left unchanged.
- R10: After reset, `smp_valid`, `smp_trig`, `sup_code` and `rf_code` are 0. The codes change only on a clock where `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Request to play periods back to back |
| cfg_period | input | 24 | Period length in samples |
| cfg_ped_len | input | 24 | Supply pedestal length in samples |
| cfg_pulse_len | input | 24 | Pulse length per path (ramp plus flat top) in samples |
| cfg_delay | input | 24 | RF start offset after supply pulse start, in samples |
| cfg_ramp_len | input | 24 | Ramp length in samples, limited to the table depth |
| cfg_ped_level | input | 16 | Supply pedestal code |
| cfg_sup_gain | input | 16 | Supply gain, unsigned Q4.12 |
| cfg_rf_gain | input | 16 | RF gain, unsigned Q4.12 |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 1 | Table select: 0 supply, 1 RF |
| tbl_addr | input | 12 | Table write address |
| tbl_data | input | 16 | Table write data |
| smp_valid | output | 1 | Sample strobe |
| smp_trig | output | 1 | Master trigger at sample index 0 |
| sup_code | output | 16 | Supply command code |
| rf_code | output | 16 | RF amplitude command code |

## Verification
A sample counter that slips, or a period boundary that is missed, shows up within one period. The trigger moves off the first sample, and every segment edge shifts by the same amount on both paths. A captured setting that leaks through mid-period changes the pedestal or the scaled ramp codes at the very next strobe after the write. A wrong delay or table select shows only on the RF codes, starting at the first strobe where the RF pulse should begin. A fault in the divider pattern shows on the first gap between strobes that is not 12 or 13 clocks, or on two equal gaps in a row.

// File: rtl/pes_pkg.sv
package pes_pkg;
  parameter int TIME_W    = 24;
  parameter int CODE_W    = 16;
  parameter int GAIN_W    = 16;
  parameter int GAIN_FRAC = 12;

  typedef enum logic [1:0] {SEG_OFF, SEG_PED, SEG_RAMP, SEG_FLAT} seg_e;

  typedef struct packed {
    logic [TIME_W-1:0] period;
    logic [TIME_W-1:0] ped_len;
    logic [TIME_W-1:0] pulse_len;
    logic [TIME_W-1:0] delay;
    logic [TIME_W-1:0] ramp_len;
    logic [CODE_W-1:0] ped_level;
    logic [GAIN_W-1:0] sup_gain;
    logic [GAIN_W-1:0] rf_gain;
  } cfg_t;
endpackage

// File: rtl/pes_tick_gen.sv
module pes_tick_gen #(
  parameter int TICK_X2 = 25
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int LO = TICK_X2 / 2;
  localparam int HI = TICK_X2 - LO;
  localparam int CW = $clog2(HI + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          long_q, long_d;
  logic [CW-1:0] lim;

  always_comb begin
    lim    = long_q ? CW'(HI - 1) : CW'(LO - 1);
    tick   = (cnt_q == lim);
    cnt_d  = tick ? '0 : cnt_q + 1'b1;
    long_d = tick ? ~long_q : long_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      long_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      long_q <= long_d;
    end
  end
endmodule

// File: rtl/pes_timeline.sv
module pes_timeline
  import pes_pkg::*;
#(
  parameter int DEPTH = 3000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  cfg_t              cfg_in,
  output logic              emit,
  output logic              load,
  output logic [TIME_W-1:0] t_idx,
  output cfg_t              cfg_q
);
  logic              active_q, active_d;
  logic [TIME_W-1:0] t_q, t_d;
  cfg_t              cfg_d, cfg_clip;
  logic              last;

  always_comb begin
    cfg_clip = cfg_in;
    if (cfg_in.ramp_len > TIME_W'(DEPTH)) cfg_clip.ramp_len = TIME_W'(DEPTH);
    last = active_q && (({1'b0, t_q} + 1'b1) >= {1'b0, cfg_q.period});
    emit = tick && active_q;
    load = tick && run && (!active_q || last);
    active_d = active_q;
    t_d      = t_q;
    cfg_d    = cfg_q;
    if (tick) begin
      if (!active_q) begin
        if (run) begin
          active_d = 1'b1;
          t_d      = '0;
        end
      end else if (last) begin
        t_d      = '0;
        active_d = run;
      end else begin
        t_d = t_q + 1'b1;
      end
    end
    if (load) cfg_d = cfg_clip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      t_q      <= '0;
      cfg_q    <= '0;
    end else begin
      active_q <= active_d;
      t_q      <= t_d;
      cfg_q    <= cfg_d;
    end
  end

  assign t_idx = t_q;
endmodule

// File: rtl/pes_path.sv
module pes_path
  import pes_pkg::*;
#(
  parameter int DEPTH   = 3000,
  parameter bit HAS_PED = 1'b1,
  parameter int AW      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              emit,
  input  logic [TIME_W-1:0] t_idx,
  input  logic [TIME_W:0]   start,
  input  logic [TIME_W-1:0] ramp_len,
  input  logic [TIME_W-1:0] pulse_len,
  input  logic [CODE_W-1:0] ped_level,
  input  logic [GAIN_W-1:0] gain,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] code
);
  localparam int PW = CODE_W + GAIN_W;
  localparam logic [PW-1:0] FULL = PW'({CODE_W{1'b1}});

  logic [CODE_W-1:0] tbl [DEPTH];

  seg_e              seg, seg_q;
  logic [TIME_W:0]   tt, rel;
  logic [AW-1:0]     rd_addr;
  logic [CODE_W-1:0] rd_q;
  logic [GAIN_W-1:0] gain_q;
  logic [CODE_W-1:0] ped_q;
  logic              e1_q;
  logic [CODE_W-1:0] base;
  logic [PW-1:0]     prod, shifted;
  logic [CODE_W-1:0] value, code_q;

  // segment decode on the current sample index
  always_comb begin
    tt  = {1'b0, t_idx};
    rel = tt - start;
    if (tt < start)                      seg = HAS_PED ? SEG_PED : SEG_OFF;
    else if (rel >= {1'b0, pulse_len})   seg = SEG_OFF;
    else if (rel < {1'b0, ramp_len})     seg = SEG_RAMP;
    else                                 seg = SEG_FLAT;
    rd_addr = (seg == SEG_RAMP) ? rel[AW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tbl[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (emit) rd_q <= tbl[rd_addr];
  end

  // stage 1 registers: segment and the settings that belong to this sample
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_OFF;
      gain_q <= '0;
      ped_q  <= '0;
      e1_q   <= 1'b0;
    end else begin
      e1_q <= emit;
      if (emit) begin
        seg_q  <= seg;
        gain_q <= gain;
        ped_q  <= ped_level;
      end
    end
  end

  // stage 2: scale and clamp
  always_comb begin
    base    = (seg_q == SEG_RAMP) ? rd_q : {CODE_W{1'b1}};
    prod    = PW'(base) * PW'(gain_q);
    shifted = prod >> GAIN_FRAC;
    case (seg_q)
      SEG_PED:  value = ped_q;
      SEG_OFF:  value = '0;
      default:  value = (shifted > FULL) ? {CODE_W{1'b1}} : shifted[CODE_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code_q <= '0;
    else if (e1_q) code_q <= value;
  end

  assign code = code_q;
endmodule

// File: rtl/env_pulse_seq.sv
module env_pulse_seq
  import pes_pkg::*;
#(
  parameter int RAMP_DEPTH = 3000,
  parameter int TICK_X2    = 25,
  parameter int AW         = $clog2(RAMP_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TIME_W-1:0] cfg_period,
  input  logic [TIME_W-1:0] cfg_ped_len,
  input  logic [TIME_W-1:0] cfg_pulse_len,
  input  logic [TIME_W-1:0] cfg_delay,
  input  logic [TIME_W-1:0] cfg_ramp_len,
  input  logic [CODE_W-1:0] cfg_ped_level,
  input  logic [GAIN_W-1:0] cfg_sup_gain,
  input  logic [GAIN_W-1:0] cfg_rf_gain,
  input  logic              tbl_we,
  input  logic              tbl_sel,
  input  logic [AW-1:0]     tbl_addr,
  input  logic [CODE_W-1:0] tbl_data,
  output logic              smp_valid,
  output logic              smp_trig,
  output logic [CODE_W-1:0] sup_code,
  output logic [CODE_W-1:0] rf_code
);
  localparam int NPATH = 2;

  logic [1:0]        rs_q;
  logic              rst_s_n;
  logic              tick, emit, cfg_load;
  logic [TIME_W-1:0] t_idx;
  cfg_t              cfg_in, cfg_q;
  logic              e1_q, t1_q, valid_q, trig_q;
  logic [CODE_W-1:0] codes [NPATH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  always_comb begin
    cfg_in.period    = cfg_period;
    cfg_in.ped_len   = cfg_ped_len;
    cfg_in.pulse_len = cfg_pulse_len;
    cfg_in.delay     = cfg_delay;
    cfg_in.ramp_len  = cfg_ramp_len;
    cfg_in.ped_level = cfg_ped_level;
    cfg_in.sup_gain  = cfg_sup_gain;
    cfg_in.rf_gain   = cfg_rf_gain;
  end

  pes_tick_gen #(.TICK_X2(TICK_X2)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .tick(tick)
  );

  pes_timeline #(.DEPTH(RAMP_DEPTH)) u_tl (
    .clk(clk), .rst_n(rst_s_n), .tick(tick), .run(run), .cfg_in(cfg_in),
    .emit(emit), .load(cfg_load), .t_idx(t_idx), .cfg_q(cfg_q)
  );

  for (genvar g = 0; g < NPATH; g++) begin : g_path
    localparam bit IS_RF = (g == 1);
    logic [TIME_W:0]   start;
    logic [GAIN_W-1:0] gain;
    logic [CODE_W-1:0] ped;
    always_comb begin
      start = IS_RF ? ({1'b0, cfg_q.ped_len} + {1'b0, cfg_q.delay})
                    : {1'b0, cfg_q.ped_len};
      gain  = IS_RF ? cfg_q.rf_gain : cfg_q.sup_gain;
      ped   = IS_RF ? '0 : cfg_q.ped_level;
    end
    pes_path #(.DEPTH(RAMP_DEPTH), .HAS_PED(!IS_RF), .AW(AW)) u_path (
      .clk(clk), .rst_n(rst_s_n), .emit(emit), .t_idx(t_idx),
      .start(start), .ramp_len(cfg_q.ramp_len), .pulse_len(cfg_q.pulse_len),
      .ped_level(ped), .gain(gain),
      .wr_en(tbl_we && (tbl_sel == 1'(g))), .wr_addr(tbl_addr),
      .wr_data(tbl_data), .code(codes[g])
    );
  end

  // strobe and trigger follow the two-stage path pipeline
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_q    <= 1'b0;
      t1_q    <= 1'b0;
      valid_q <= 1'b0;
      trig_q  <= 1'b0;
    end else if (!rst_s_n) begin
      e1_q    <= 1'b0;
      t1_q    <= 1'b0;
      valid_q <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      e1_q    <= emit;
      t1_q    <= emit && (t_idx == '0);
      valid_q <= e1_q;
      trig_q  <= t1_q;
    end
  end

  assign smp_valid = valid_q;
  assign smp_trig  = trig_q;
  assign sup_code  = codes[0];
  assign rf_code   = codes[1];
endmodule

// File: rtl/env_pulse_seq_chk.sv
module env_pulse_seq_chk
  import pes_pkg::*;
#(
  parameter int TICK_X2 = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              smp_trig,
  input logic [CODE_W-1:0] sup_code,
  input logic [CODE_W-1:0] rf_code,
  input cfg_t              cfg_q,
  input logic              cfg_load
);
  localparam int LO = TICK_X2 / 2;
  localparam int HI = TICK_X2 - LO;

  logic [7:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= 8'hFF;
    else if (smp_valid)  gap_q <= 8'd1;
    else if (gap_q != 8'hFF) gap_q <= gap_q + 8'd1;
  end

  // R1: strobes never closer than the short divider interval while running
  p_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && gap_q <= 8'(HI)) |-> (gap_q >= 8'(LO)));

  // R2: trigger only together with a strobe
  p_trig_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_trig |-> smp_valid);

  // R2: trigger is a single-clock pulse
  p_trig_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_trig |=> !smp_trig);

  // R7: captured settings move only at a period boundary
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(cfg_q));

  // R10: codes change only with the strobe
  p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> ($stable(sup_code) && $stable(rf_code)));
endmodule

bind env_pulse_seq env_pulse_seq_chk #(.TICK_X2(TICK_X2)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .smp_valid(smp_valid), .smp_trig(smp_trig),
  .sup_code(sup_code), .rf_code(rf_code), .cfg_q(cfg_q), .cfg_load(cfg_load)
);

// File: tb/env_pulse_seq_tb.sv
module env_pulse_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [23:0] cfg_period, cfg_ped_len, cfg_pulse_len, cfg_delay, cfg_ramp_len;
  logic [15:0] cfg_ped_level, cfg_sup_gain, cfg_rf_gain;
  logic        tbl_we, tbl_sel;
  logic [11:0] tbl_addr;
  logic [15:0] tbl_data;
  logic        smp_valid, smp_trig;
  logic [15:0] sup_code, rf_code;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  env_pulse_seq u_dut (.*);

  // {supply, rf} per sample index for two periods (R3 R4 R5 R6 R7 R9)
  localparam logic [31:0] EXP [40] = '{
    32'h61A9_0000, 32'h61A9_0000, 32'h61A9_0000, 32'h03E8_0000, 32'h07D0_0000,
    32'h0BB8_020E, 32'h0FA0_040E, 32'hFFFF_060E, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
    32'h1234_0000, 32'h1234_0000, 32'h1234_0000, 32'h01F4_0000, 32'h03E8_0000,
    32'h05DC_020E, 32'h07D0_040E, 32'h7FFF_060E, 32'h7FFF_FFFF, 32'h7FFF_FFFF,
    32'h7FFF_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0000, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_tbl(input logic sel, input logic [11:0] a, input logic [15:0] d);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = a; tbl_data = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic next_sample(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!smp_valid && gap < 200);
  endtask

  task automatic quiet(input int n, input string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (smp_valid) seen++;
    end
    check(req, 32'(seen), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap, prev_gap;
    run = 0; tbl_we = 0; tbl_sel = 0; tbl_addr = '0; tbl_data = '0;
    cfg_period = 24'd20; cfg_ped_len = 24'd3; cfg_pulse_len = 24'd8;
    cfg_delay = 24'd2; cfg_ramp_len = 24'd4; cfg_ped_level = 16'h61A9;
    cfg_sup_gain = 16'h1000; cfg_rf_gain = 16'h2000;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 valid", 32'(smp_valid), 0);
    check("R10 trig", 32'(smp_trig), 0);
    check("R10 codes", {sup_code, rf_code}, 0);

    // R9: distinct contents per table; RF entry 3 forces the clamp (R5)
    for (int i = 0; i < 8; i++) begin
      wr_tbl(1'b0, 12'(i), 16'(1000 * (i + 1)));
      wr_tbl(1'b1, 12'(i), (i == 3) ? 16'h9000 : 16'(256 * (i + 1) + 7));
    end
    quiet(60, "R8 idle before run");

    run = 1'b1;
    prev_gap = 0;
    for (int k = 0; k < 40; k++) begin
      next_sample(gap);
      check($sformatf("R3-R6 sample %0d", k), {sup_code, rf_code}, EXP[k]);
      check($sformatf("R2 trig %0d", k), 32'(smp_trig), 32'((k % 20) == 0));
      if (k > 0) begin
        check("R1 gap range", 32'(gap == 12 || gap == 13), 1);
        if (k > 1) check("R1 gap alternates", 32'(gap != prev_gap), 1);
      end
      prev_gap = gap;
      if (k == 6) begin
        // R7: mid-period change must wait for the next period
        cfg_ped_level = 16'h1234;
        cfg_sup_gain  = 16'h0800;
      end
      if (k == 30) run = 1'b0;
    end
    quiet(300, "R8 stop at boundary");
    check("R8 hold codes", {sup_code, rf_code}, 0);

    // corner: no ramp (R5), RF delay past the period end (R6)
    cfg_period = 24'd6; cfg_ped_len = 24'd0; cfg_ramp_len = 24'd0;
    cfg_pulse_len = 24'd3; cfg_delay = 24'd10; cfg_sup_gain = 16'h1000;
    run = 1'b1;
    for (int k = 0; k < 6; k++) begin
      next_sample(gap);
      if (k == 0) run = 1'b0;
      check($sformatf("R5 flat-only sup %0d", k), 32'(sup_code), (k < 3) ? 32'hFFFF : 0);
      check($sformatf("R6 late rf %0d", k), 32'(rf_code), 0);
      check($sformatf("R2 trig corner %0d", k), 32'(smp_trig), 32'(k == 0));
    end
    quiet(200, "R8 single period");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule